// File: doc/BRIEF.md
# Decimal ALU with Digit Shifter

This block is a purely combinational arithmetic stage for three-digit packed BCD words. A left and a right operand enter an arithmetic unit that can produce zero, a decimal sum, the left operand unchanged, or the nine's complement of the left operand. The result then passes through a shifter that moves the word by one whole decimal digit.

Three results leave the block. The first is the shifted word. The second is a sign flag that reads the arithmetic result under ten's complement rules, where 500 to 999 are negative. The third is a digit-wide flag that holds the digit pushed out of the top by a left shift or a left rotate. Branch logic downstream compares that digit against a constant from 0 to 9, so one shift-and-compare step can tell which opcode digit a word carries.

The block holds no state. Its outputs follow its inputs within the same evaluation.

Top module: `decimal_alu`

## Requirements
- R1: Each word packs its digits four bits apiece, with the units digit at bits [3:0], the tens digit at [7:4] and the hundreds digit at [11:8]. When both operands hold only the digits 0 to 9, every digit of `result_o` also lies in 0 to 9.
- R2: Arithmetic code 2'b00 makes the arithmetic result 000. `result_o` is then 000 for every shift code, and both flags are 0.
- R3: Arithmetic code 2'b01 adds the two operands in decimal and carries between digits. A carry out of the hundreds digit is dropped, so the sum wraps modulo 1000 (020+001=021, 999+001=000).
- R4: Arithmetic code 2'b10 passes the left operand through unchanged.
- R5: Arithmetic code 2'b11 gives the nine's complement of the left operand: each digit d becomes 9-d.
- R6: `neg_o` is 1 exactly when the arithmetic result, taken before the shift, lies in 500 to 999. The shift code has no effect on it.
- R7: Shift code 2'b00 passes the arithmetic result to `result_o` unchanged, with `carry_digit_o` at 0.
- R8: Shift code 2'b01 moves the word one digit toward the units end and puts 0 into the hundreds digit. `carry_digit_o` is 0.
- R9: Shift code 2'b10 moves the word one digit toward the hundreds end and puts 0 into the units digit. The old hundreds digit goes to `carry_digit_o` (040 gives 400 with a carry digit of 0).
- R10: Shift code 2'b11 rotates the word left by one digit. The old hundreds digit lands in the units digit and also in `carry_digit_o`.
- R11: The right operand affects no output under any arithmetic code other than 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| left_i | input | 12 | Left operand, packed BCD |
| right_i | input | 12 | Right operand, packed BCD |
| alu_op_i | input | 2 | Arithmetic code: 00 zero, 01 add, 10 pass left, 11 nine's complement |
| shift_op_i | input | 2 | Shift code: 00 none, 01 right, 10 left, 11 rotate left |
| result_o | output | 12 | Shifted result, packed BCD |
| neg_o | output | 1 | Arithmetic result is in 500..999 |
| carry_digit_o | output | 4 | Digit moved out of the top by a left shift or rotate, else 0 |

## Verification
The block holds no state, so any fault shows up at the ports in the same evaluation as the stimulus that triggers it. A wrong inter-digit carry shows as a units, tens or hundreds digit off by one, or as a digit above 9. Such faults appear only for operands whose digit sums cross 9, so the directed cases include 9-to-0 rollovers at each digit position and a full wrap past 999. A mis-wired shifter shows as a misplaced or missing digit, or as a carry digit that is nonzero on a shift that should leave it at 0. The bench varies the shift code while holding the arithmetic result fixed. This tells a shift fault apart from a sign-flag fault.

// File: rtl/dalu_pkg.sv
package dalu_pkg;
  localparam int DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [1:0] {
    ALU_ZERO  = 2'b00,
    ALU_ADD   = 2'b01,
    ALU_PASS  = 2'b10,
    ALU_NINES = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_LEFT  = 2'b10,
    SH_ROTL  = 2'b11
  } shift_op_e;
endpackage

// File: rtl/dalu_bcd_adder.sv
module dalu_bcd_adder
  import dalu_pkg::*;
#(
  parameter int NUM_DIGITS = 3
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] a_i,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] b_i,
  output logic [NUM_DIGITS*DIGIT_W-1:0] sum_o
);
  // carry into each digit; carry out of the top digit is dropped
  logic [NUM_DIGITS-1:0] cin;
  assign cin[0] = 1'b0;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    logic [DIGIT_W:0] raw;
    logic [DIGIT_W:0] adj;
    logic             over;
    assign raw  = {1'b0, a_i[k*DIGIT_W +: DIGIT_W]} + {1'b0, b_i[k*DIGIT_W +: DIGIT_W]}
                + {{DIGIT_W{1'b0}}, cin[k]};
    assign over = raw > (DIGIT_W+1)'(9);
    assign adj  = raw - (DIGIT_W+1)'(10);
    assign sum_o[k*DIGIT_W +: DIGIT_W] = over ? adj[DIGIT_W-1:0] : raw[DIGIT_W-1:0];
    if (k < NUM_DIGITS-1) begin : g_chain
      assign cin[k+1] = over;
    end
  end
endmodule

// File: rtl/dalu_arith.sv
module dalu_arith
  import dalu_pkg::*;
#(
  parameter int NUM_DIGITS = 3
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] left_i,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] right_i,
  input  alu_op_e                       op_i,
  output logic [NUM_DIGITS*DIGIT_W-1:0] res_o
);
  localparam int W = NUM_DIGITS*DIGIT_W;

  logic [W-1:0] sum;
  logic [W-1:0] nines;

  dalu_bcd_adder #(.NUM_DIGITS(NUM_DIGITS)) u_add (
    .a_i  (left_i),
    .b_i  (right_i),
    .sum_o(sum)
  );

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_nines
    assign nines[k*DIGIT_W +: DIGIT_W] = digit_t'(9) - left_i[k*DIGIT_W +: DIGIT_W];
  end

  always_comb begin
    unique case (op_i)
      ALU_ADD:   res_o = sum;
      ALU_PASS:  res_o = left_i;
      ALU_NINES: res_o = nines;
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/dalu_shifter.sv
module dalu_shifter
  import dalu_pkg::*;
#(
  parameter int NUM_DIGITS = 3
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] in_i,
  input  shift_op_e                     op_i,
  output logic [NUM_DIGITS*DIGIT_W-1:0] out_o,
  output digit_t                        carry_o
);
  localparam int W = NUM_DIGITS*DIGIT_W;

  digit_t top;
  assign top = in_i[W-1 -: DIGIT_W];

  always_comb begin
    carry_o = '0;
    unique case (op_i)
      SH_RIGHT: out_o = {{DIGIT_W{1'b0}}, in_i[W-1:DIGIT_W]};
      SH_LEFT: begin
        out_o   = {in_i[W-DIGIT_W-1:0], {DIGIT_W{1'b0}}};
        carry_o = top;
      end
      SH_ROTL: begin
        out_o   = {in_i[W-DIGIT_W-1:0], top};
        carry_o = top;
      end
      default:  out_o = in_i;
    endcase
  end
endmodule

// File: rtl/decimal_alu.sv
module decimal_alu
  import dalu_pkg::*;
#(
  parameter int NUM_DIGITS    = 3,
  parameter int NEG_MIN_DIGIT = 5,
  localparam int W            = NUM_DIGITS*DIGIT_W
) (
  input  logic [W-1:0]       left_i,
  input  logic [W-1:0]       right_i,
  input  logic [1:0]         alu_op_i,
  input  logic [1:0]         shift_op_i,
  output logic [W-1:0]       result_o,
  output logic               neg_o,
  output logic [DIGIT_W-1:0] carry_digit_o
);
  logic [W-1:0] arith_res;

  dalu_arith #(.NUM_DIGITS(NUM_DIGITS)) u_arith (
    .left_i (left_i),
    .right_i(right_i),
    .op_i   (alu_op_e'(alu_op_i)),
    .res_o  (arith_res)
  );

  // ten's complement sign: top digit at or above half range
  assign neg_o = arith_res[W-1 -: DIGIT_W] >= digit_t'(NEG_MIN_DIGIT);

  dalu_shifter #(.NUM_DIGITS(NUM_DIGITS)) u_shift (
    .in_i   (arith_res),
    .op_i   (shift_op_e'(shift_op_i)),
    .out_o  (result_o),
    .carry_o(carry_digit_o)
  );
endmodule

// File: rtl/decimal_alu_checks.sv
module decimal_alu_checks #(
  parameter int NUM_DIGITS = 3,
  localparam int W         = NUM_DIGITS*4
) (
  input logic [W-1:0] left_i,
  input logic [W-1:0] right_i,
  input logic [1:0]   alu_op_i,
  input logic [1:0]   shift_op_i,
  input logic [W-1:0] result_o,
  input logic         neg_o,
  input logic [3:0]   carry_digit_o
);
  function automatic logic all_bcd(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < NUM_DIGITS; k++) if (v[k*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  always_comb begin
    // R1 digits stay decimal
    a_r1_bcd_digits: assert (!(all_bcd(left_i) && all_bcd(right_i)) || all_bcd(result_o))
      else $error("R1 non-decimal digit in result");
    a_r2_zero_op: assert (alu_op_i != 2'b00 || (result_o == '0 && !neg_o && carry_digit_o == '0))
      else $error("R2 zero op not zero");
    a_r4_pass_left: assert (!(alu_op_i == 2'b10 && shift_op_i == 2'b00) || result_o == left_i)
      else $error("R4 pass mismatch");
    a_r6_neg_pass: assert (alu_op_i != 2'b10 || neg_o == (left_i[W-1 -: 4] >= 4'd5))
      else $error("R6 sign of passed word");
    a_r7_quiet_carry: assert (shift_op_i[1] || carry_digit_o == '0)
      else $error("R7/R8 carry digit nonzero");
    a_r8_right_fill: assert (shift_op_i != 2'b01 || result_o[W-1 -: 4] == '0)
      else $error("R8 top digit not cleared");
    a_r9_left_fill: assert (shift_op_i != 2'b10 || result_o[3:0] == '0)
      else $error("R9 units digit not cleared");
    a_r10_rotate_wrap: assert (shift_op_i != 2'b11 || result_o[3:0] == carry_digit_o)
      else $error("R10 rotated digit mismatch");
  end
endmodule

bind decimal_alu decimal_alu_checks #(.NUM_DIGITS(NUM_DIGITS)) u_checks (
  .left_i       (left_i),
  .right_i      (right_i),
  .alu_op_i     (alu_op_i),
  .shift_op_i   (shift_op_i),
  .result_o     (result_o),
  .neg_o        (neg_o),
  .carry_digit_o(carry_digit_o)
);

// File: tb/decimal_alu_test.sv
module decimal_alu_test;
  logic        clk;
  logic        rst_ni;
  logic [11:0] left_i, right_i;
  logic [1:0]  alu_op_i, shift_op_i;
  logic [11:0] result_o;
  logic        neg_o;
  logic [3:0]  carry_digit_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  decimal_alu uut (
    .left_i       (left_i),
    .right_i      (right_i),
    .alu_op_i     (alu_op_i),
    .shift_op_i   (shift_op_i),
    .result_o     (result_o),
    .neg_o        (neg_o),
    .carry_digit_o(carry_digit_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [11:0] to_bcd(input int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  // drive decimal values, compare against integer model
  task automatic apply(input string req, input int l, input int r, input logic [1:0] op,
                       input logic [1:0] sh);
    int a, v, c;
    @(posedge clk);
    left_i     = to_bcd(l);
    right_i    = to_bcd(r);
    alu_op_i   = op;
    shift_op_i = sh;
    case (op)
      2'b01:   a = (l + r) % 1000;
      2'b10:   a = l;
      2'b11:   a = 999 - l;
      default: a = 0;
    endcase
    c = 0;
    case (sh)
      2'b01: v = a / 10;
      2'b10: begin v = (a % 100) * 10; c = a / 100; end
      2'b11: begin v = (a % 100) * 10 + a / 100; c = a / 100; end
      default: v = a;
    endcase
    @(negedge clk);
    check(req, "result", int'(result_o), int'(to_bcd(v)));
    check(req, "neg", int'(neg_o), (a >= 500) ? 1 : 0);
    check(req, "carry_digit", int'(carry_digit_o), c);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check("R2", "idle result", int'(result_o), 0);
    check("R2", "idle neg", int'(neg_o), 0);
    check("R2", "idle carry", int'(carry_digit_o), 0);
  endtask

  task automatic t_zero_op;
    for (int s = 0; s < 4; s++) apply("R2", 987, 654, 2'b00, 2'(s));
  endtask

  task automatic t_add;
    apply("R3", 20, 1, 2'b01, 2'b00);
    apply("R3", 999, 1, 2'b01, 2'b00);
    apply("R3", 9, 1, 2'b01, 2'b00);
    apply("R3", 95, 5, 2'b01, 2'b00);
    apply("R3", 555, 555, 2'b01, 2'b00);
    apply("R3", 499, 1, 2'b01, 2'b00);
    apply("R3", 999, 999, 2'b01, 2'b00);
  endtask

  task automatic t_pass_and_nines;
    apply("R4", 40, 0, 2'b10, 2'b00);
    apply("R4", 731, 222, 2'b10, 2'b00);
    apply("R5", 40, 0, 2'b11, 2'b00);
    apply("R5", 0, 0, 2'b11, 2'b00);
    apply("R5", 999, 0, 2'b11, 2'b00);
  endtask

  task automatic t_sign;
    apply("R6", 499, 0, 2'b10, 2'b00);
    apply("R6", 500, 0, 2'b10, 2'b00);
    apply("R6", 999, 0, 2'b10, 2'b01);
    apply("R6", 500, 0, 2'b10, 2'b10);
  endtask

  task automatic t_shifts;
    apply("R7", 123, 0, 2'b10, 2'b00);
    apply("R8", 123, 0, 2'b10, 2'b01);
    apply("R8", 907, 0, 2'b10, 2'b01);
    apply("R9", 40, 0, 2'b10, 2'b10);
    apply("R9", 987, 0, 2'b10, 2'b10);
    apply("R10", 987, 0, 2'b10, 2'b11);
    apply("R10", 40, 0, 2'b10, 2'b11);
  endtask

  task automatic t_right_ignored;
    apply("R11", 314, 0, 2'b10, 2'b11);
    apply("R11", 314, 999, 2'b10, 2'b11);
    apply("R11", 314, 555, 2'b11, 2'b10);
    apply("R11", 314, 123, 2'b00, 2'b00);
  endtask

  task automatic t_sweep;
    for (int l = 0; l < 1000; l += 37)
      for (int op = 0; op < 4; op++)
        for (int sh = 0; sh < 4; sh++)
          apply("R1", l, (l * 7 + 13) % 1000, 2'(op), 2'(sh));
  endtask

  initial begin
    rst_ni     = 1'b0;
    left_i     = '0;
    right_i    = '0;
    alu_op_i   = '0;
    shift_op_i = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_zero_op();
    t_add();
    t_pass_and_nines();
    t_sign();
    t_shifts();
    t_right_ignored();
    t_sweep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule